// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block manages a single DRAM bank. It takes one read or write request at a time, each with a row and a column address, and emits the ACTIVATE, READ, WRITE and PRECHARGE commands needed to serve it. It remembers which row is open. If the requested row is already open (a hit), the block issues only the column command. If a different row is open (a conflict), it closes that row, opens the new one and then issues the column command. If the bank is closed, it opens the row and then issues the column command.

Every command waits until the spacing rules allow it. These rules are counted in controller clocks: activate-to-column, precharge-to-activate, minimum row-open time, write recovery and burst occupancy. After an access the row stays open. If no new request is accepted within an idle window, the block closes the row with a PRECHARGE. A column command can also carry auto-precharge. In that case the bank closes internally once the row may legally close, and no separate PRECHARGE is emitted.

Commands are combinational decodes of registered state, so a command never appears earlier than the cycle after the request is accepted. In the command strobe, bit 0 is ACTIVATE, bit 1 is READ, bit 2 is WRITE and bit 3 is PRECHARGE.

Top module: `bank_seq`

## Requirements
- R1: Reset state.
  - After reset, no command is strobed and `req_ready` is high.
  - The bank is closed, so the first request starts with an ACTIVATE in the cycle after acceptance and no PRECHARGE.
- R2: Command encoding.
  - At most one strobe bit is high in any cycle: bit 0 ACTIVATE, bit 1 READ, bit 2 WRITE, bit 3 PRECHARGE.
  - `cmd_row` carries the row on ACTIVATE and the closing row on PRECHARGE, and is 0 otherwise.
  - `cmd_col`, `cmd_auto_pre` and `cmd_burst16` carry the request's values on READ or WRITE, and are 0 otherwise.
- R3: Row hit.
  - A request to the open row is served by a single READ or WRITE.
  - If no spacing rule holds it back, that command comes in the cycle after acceptance.
- R4: Row conflict.
  - A request to a different row than the open one produces PRECHARGE of the old row, then ACTIVATE of the new row, then the column command, in that order.
  - An ACTIVATE is never issued while a row is open.
- R5: A READ or WRITE comes no earlier than T_RCD cycles after the ACTIVATE of its row.
- R6: An ACTIVATE comes no earlier than T_RP cycles after the preceding PRECHARGE or internal close.
- R7: A PRECHARGE comes no earlier than T_RAS cycles after the ACTIVATE of the row it closes.
- R8: Precharge after a column command.
  - After a WRITE, the row closes no earlier than T_CL + burst + T_WR cycles after the WRITE.
  - After a READ, the row closes no earlier than burst cycles after the READ.
- R9: Burst length.
  - `req_burst16` = 0 selects an 8-beat burst, which occupies 4 clocks; 1 selects a 16-beat burst, which occupies 8 clocks.
  - A column command comes no earlier than the previous burst's clocks after the previous column command.
- R10: Idle close.
  - If no request is accepted after a non-auto-precharge column command, PRECHARGE is issued at the first cycle at least T_IDLE cycles after that command at which R7 and R8 also allow it.
  - `req_ready` is low in that cycle.
- R11: Auto-precharge.
  - A column command with auto-precharge emits no PRECHARGE.
  - The bank closes at the first cycle, after the command, at which R7 and R8 allow it.
  - The next access, to any row, begins with an ACTIVATE that obeys R6.
- R12: Handshake.
  - A request is accepted when `req_valid` and `req_ready` are both high.
  - `req_ready` is low in the cycle after acceptance, and stays low until the request's column command has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_auto_pre | input | 1 | Close the row after this access |
| req_burst16 | input | 1 | 1 = 16-beat burst, 0 = 8-beat burst |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| cmd_strobe | output | 4 | One-hot command: bit0 ACT, bit1 RD, bit2 WR, bit3 PRE |
| cmd_row | output | ROW_W | Row address for ACT or PRE |
| cmd_col | output | COL_W | Column address for RD or WR |
| cmd_auto_pre | output | 1 | Auto-precharge flag on RD or WR |
| cmd_burst16 | output | 1 | Burst length flag on RD or WR |

## Verification
A request accepted in cycle a can produce its first command in cycle a+1 at the earliest. Every later command is due at the largest of that cycle and each spacing bound that applies: the previous ACTIVATE plus T_RCD or T_RAS, the last close plus T_RP, and the last column command plus burst, recovery or T_IDLE. The bench works out each due cycle from its own record of the commands issued so far. It stamps every expected command with that cycle, and compares it against the cycle counter sampled at the falling edge in which the command is seen. An idle close is predicted lazily: it is added to the expected list only once the next acceptance, or the end of the run, shows that the idle window ran out.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPEN,
    S_PRE,
    S_ACT,
    S_COL,
    S_AUTOPRE
  } seq_state_e;

  localparam int CMD_W   = 4;
  localparam int CMD_ACT = 0;
  localparam int CMD_RD  = 1;
  localparam int CMD_WR  = 2;
  localparam int CMD_PRE = 3;

  localparam int TI_RCD  = 0;
  localparam int TI_RP   = 1;
  localparam int TI_RAS  = 2;
  localparam int TI_CP   = 3;
  localparam int TI_BUSY = 4;
  localparam int TI_IDLE = 5;
  localparam int NTIMER  = 6;

endpackage

// File: rtl/bank_seq_timer.sv
module bank_seq_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q, cnt_d;

  // A load of N makes done true N cycles after the loading cycle (N >= 1).
  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/bank_seq_ctrl.sv
module bank_seq_ctrl
  import bank_seq_pkg::*;
#(
  parameter int ROW_W   = 14,
  parameter int COL_W   = 10,
  parameter int CW      = 5,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RAS   = 8,
  parameter int T_WR    = 4,
  parameter int T_CL    = 5,
  parameter int T_IDLE  = 20,
  parameter int BURST_S = 4,
  parameter int BURST_L = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic                     req_auto_pre,
  input  logic                     req_burst16,
  input  logic [ROW_W-1:0]         req_row,
  input  logic [COL_W-1:0]         req_col,
  input  logic [NTIMER-1:0]        t_done,
  output logic [NTIMER-1:0]        t_load,
  output logic [NTIMER-1:0][CW-1:0] t_val,
  output logic [CMD_W-1:0]         cmd_strobe,
  output logic [ROW_W-1:0]         cmd_row,
  output logic [COL_W-1:0]         cmd_col,
  output logic                     cmd_auto_pre,
  output logic                     cmd_burst16
);

  seq_state_e       state_q, state_d;
  logic [ROW_W-1:0] pend_row_q, open_row_q;
  logic [COL_W-1:0] pend_col_q;
  logic             pend_wr_q, pend_ap_q, pend_b16_q;
  logic             accept, open_en;
  logic [CW-1:0]    burst_clk;
  logic             close_ok;

  assign burst_clk = pend_b16_q ? CW'(BURST_L) : CW'(BURST_S);
  assign close_ok  = t_done[TI_RAS] && t_done[TI_CP];

  always_comb begin
    state_d    = state_q;
    req_ready  = 1'b0;
    accept     = 1'b0;
    open_en    = 1'b0;
    cmd_strobe = '0;
    t_load     = '0;
    t_val[TI_RCD]  = CW'(T_RCD);
    t_val[TI_RP]   = CW'(T_RP);
    t_val[TI_RAS]  = CW'(T_RAS);
    t_val[TI_IDLE] = CW'(T_IDLE);
    t_val[TI_BUSY] = burst_clk;
    t_val[TI_CP]   = pend_wr_q ? (CW'(T_CL + T_WR) + burst_clk) : burst_clk;
    case (state_q)
      S_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          accept  = 1'b1;
          state_d = S_ACT;
        end
      end
      S_OPEN: begin
        if (t_done[TI_IDLE] && close_ok) begin
          cmd_strobe[CMD_PRE] = 1'b1;
          t_load[TI_RP]       = 1'b1;
          state_d             = S_IDLE;
        end else begin
          req_ready = 1'b1;
          if (req_valid) begin
            accept  = 1'b1;
            state_d = (req_row == open_row_q) ? S_COL : S_PRE;
          end
        end
      end
      S_PRE: begin
        if (close_ok) begin
          cmd_strobe[CMD_PRE] = 1'b1;
          t_load[TI_RP]       = 1'b1;
          state_d             = S_ACT;
        end
      end
      S_ACT: begin
        if (t_done[TI_RP]) begin
          cmd_strobe[CMD_ACT] = 1'b1;
          t_load[TI_RCD]      = 1'b1;
          t_load[TI_RAS]      = 1'b1;
          open_en             = 1'b1;
          state_d             = S_COL;
        end
      end
      S_COL: begin
        if (t_done[TI_RCD] && t_done[TI_BUSY]) begin
          cmd_strobe[pend_wr_q ? CMD_WR : CMD_RD] = 1'b1;
          t_load[TI_BUSY] = 1'b1;
          t_load[TI_CP]   = 1'b1;
          t_load[TI_IDLE] = 1'b1;
          state_d         = pend_ap_q ? S_AUTOPRE : S_OPEN;
        end
      end
      S_AUTOPRE: begin
        if (close_ok) begin
          t_load[TI_RP] = 1'b1;
          state_d       = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      pend_row_q <= '0;
      pend_col_q <= '0;
      pend_wr_q  <= 1'b0;
      pend_ap_q  <= 1'b0;
      pend_b16_q <= 1'b0;
      open_row_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        pend_row_q <= req_row;
        pend_col_q <= req_col;
        pend_wr_q  <= req_write;
        pend_ap_q  <= req_auto_pre;
        pend_b16_q <= req_burst16;
      end
      if (open_en) begin
        open_row_q <= pend_row_q;
      end
    end
  end

  logic is_col;
  assign is_col       = cmd_strobe[CMD_RD] || cmd_strobe[CMD_WR];
  assign cmd_row      = cmd_strobe[CMD_ACT] ? pend_row_q :
                        cmd_strobe[CMD_PRE] ? open_row_q : '0;
  assign cmd_col      = is_col ? pend_col_q : '0;
  assign cmd_auto_pre = is_col && pend_ap_q;
  assign cmd_burst16  = is_col && pend_b16_q;

endmodule

// File: rtl/bank_seq.sv
module bank_seq
  import bank_seq_pkg::*;
#(
  parameter int ROW_W    = 14,
  parameter int COL_W    = 10,
  parameter int T_RCD    = 3,
  parameter int T_RP     = 3,
  parameter int T_RAS    = 8,
  parameter int T_WR     = 4,
  parameter int T_CL     = 5,
  parameter int T_IDLE   = 20,
  parameter int BL_SHORT = 8,
  parameter int BL_LONG  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_auto_pre,
  input  logic             req_burst16,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic [3:0]       cmd_strobe,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             cmd_auto_pre,
  output logic             cmd_burst16
);

  localparam int BURST_S = BL_SHORT / 2;
  localparam int BURST_L = BL_LONG / 2;
  localparam int WR_MAX  = T_CL + BURST_L + T_WR;
  localparam int M1      = (T_RAS > T_IDLE) ? T_RAS : T_IDLE;
  localparam int M2      = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int M3      = (M1 > M2) ? M1 : M2;
  localparam int MAXV    = (M3 > WR_MAX) ? M3 : WR_MAX;
  localparam int CW      = $clog2(MAXV + 1);

  logic [NTIMER-1:0]         t_done, t_load;
  logic [NTIMER-1:0][CW-1:0] t_val;

  bank_seq_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .CW(CW),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_WR(T_WR),
    .T_CL(T_CL), .T_IDLE(T_IDLE), .BURST_S(BURST_S), .BURST_L(BURST_L)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_auto_pre(req_auto_pre),
    .req_burst16(req_burst16), .req_row(req_row), .req_col(req_col),
    .t_done(t_done), .t_load(t_load), .t_val(t_val),
    .cmd_strobe(cmd_strobe), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .cmd_auto_pre(cmd_auto_pre), .cmd_burst16(cmd_burst16)
  );

  for (genvar i = 0; i < NTIMER; i++) begin : g_timer
    bank_seq_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .load(t_load[i]), .load_val(t_val[i]), .done(t_done[i])
    );
  end

endmodule

// File: rtl/bank_seq_chk.sv
module bank_seq_chk #(
  parameter int T_RCD    = 3,
  parameter int T_RP     = 3,
  parameter int T_RAS    = 8,
  parameter int BL_SHORT = 8,
  parameter int BL_LONG  = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [3:0] cmd_strobe,
  input logic       cmd_auto_pre,
  input logic       cmd_burst16
);

  localparam logic [7:0] CAP  = 8'hFF;
  localparam logic [7:0] RCD8 = 8'(T_RCD);
  localparam logic [7:0] RP8  = 8'(T_RP);
  localparam logic [7:0] RAS8 = 8'(T_RAS);
  localparam logic [7:0] BS8  = 8'(BL_SHORT / 2);
  localparam logic [7:0] BLG8 = 8'(BL_LONG / 2);

  logic [7:0] since_act, since_pre, since_col, last_burst;
  logic       open_q;
  logic       is_act, is_col, is_pre;

  assign is_act = cmd_strobe[0];
  assign is_col = cmd_strobe[1] || cmd_strobe[2];
  assign is_pre = cmd_strobe[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act  <= CAP;
      since_pre  <= CAP;
      since_col  <= CAP;
      last_burst <= '0;
      open_q     <= 1'b0;
    end else begin
      since_act <= is_act ? 8'd1 : ((since_act != CAP) ? since_act + 8'd1 : since_act);
      since_pre <= is_pre ? 8'd1 : ((since_pre != CAP) ? since_pre + 8'd1 : since_pre);
      since_col <= is_col ? 8'd1 : ((since_col != CAP) ? since_col + 8'd1 : since_col);
      if (is_col) last_burst <= cmd_burst16 ? BLG8 : BS8;
      if (is_act) open_q <= 1'b1;
      else if (is_pre || (is_col && cmd_auto_pre)) open_q <= 1'b0;
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_strobe));
  a_r12_busy_when_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe != 4'b0) |-> !req_ready);
  a_r12_one_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r4_act_on_closed: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !open_q);
  a_r3_col_on_open: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> open_q);
  a_r5_rcd: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (since_act >= RCD8));
  a_r6_rp: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (since_pre >= RP8));
  a_r7_ras: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (since_act >= RAS8));
  a_r9_burst: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (since_col >= last_burst));

endmodule

bind bank_seq bank_seq_chk #(
  .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
  .BL_SHORT(BL_SHORT), .BL_LONG(BL_LONG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_strobe(cmd_strobe), .cmd_auto_pre(cmd_auto_pre),
  .cmd_burst16(cmd_burst16)
);

// File: tb/bank_seq_bench.sv
`timescale 1ns/1ps
module bank_seq_bench;

  localparam int ROW_W  = 14;
  localparam int COL_W  = 10;
  localparam int T_RCD  = 3;
  localparam int T_RP   = 3;
  localparam int T_RAS  = 8;
  localparam int T_WR   = 4;
  localparam int T_CL   = 5;
  localparam int T_IDLE = 20;

  logic             clk, rst_n;
  logic             req_valid, req_ready, req_write, req_auto_pre, req_burst16;
  logic [ROW_W-1:0] req_row, cmd_row;
  logic [COL_W-1:0] req_col, cmd_col;
  logic [3:0]       cmd_strobe;
  logic             cmd_auto_pre, cmd_burst16;

  bank_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RAS(T_RAS), .T_WR(T_WR), .T_CL(T_CL), .T_IDLE(T_IDLE),
    .BL_SHORT(8), .BL_LONG(16)
  ) u_bank_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_auto_pre(req_auto_pre),
    .req_burst16(req_burst16), .req_row(req_row), .req_col(req_col),
    .cmd_strobe(cmd_strobe), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .cmd_auto_pre(cmd_auto_pre), .cmd_burst16(cmd_burst16)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  typedef struct {
    int               c;
    logic [3:0]       cmd;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic             ap;
    logic             b16;
    string            tag;
  } item_t;

  item_t exp_q[$];
  item_t obs_q[$];

  // bench model of the bank
  bit m_open = 0;
  bit m_first = 1;
  bit m_auto = 0;
  bit m_last_wr = 0;
  logic [ROW_W-1:0] m_row = '0;
  int t_act = -1000, t_col = -1000, t_close = -1000;
  int cp_last = 0, busy_last = 0;

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic void push(int c, logic [3:0] cmd, logic [ROW_W-1:0] row,
                               logic [COL_W-1:0] col, logic ap, logic b16, string tag);
    item_t it;
    it.c = c; it.cmd = cmd; it.row = row; it.col = col;
    it.ap = ap; it.b16 = b16; it.tag = tag;
    exp_q.push_back(it);
  endfunction

  function automatic int idle_due();
    return mx(mx(t_col + 1, t_col + T_IDLE), mx(t_act + T_RAS, t_col + cp_last));
  endfunction

  // R10: idle close happens if nothing was accepted before it fell due
  function automatic void note_timeout(int now);
    int tto;
    if (m_open) begin
      tto = idle_due();
      if (now > tto) begin
        push(tto, 4'b1000, m_row, '0, 1'b0, 1'b0, "R10");
        m_open  = 0;
        m_auto  = 0;
        t_close = tto;
      end
    end
  endfunction

  task automatic do_req(input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                        input logic wr, input logic ap, input logic b16);
    int a, p, act, c;
    string tg;
    @(negedge clk);
    req_valid = 1'b1; req_row = row; req_col = col;
    req_write = wr; req_auto_pre = ap; req_burst16 = b16;
    while (!req_ready) @(negedge clk);
    a = cyc;
    @(posedge clk);
    #1 req_valid = 1'b0;
    note_timeout(a);
    if (m_open && row == m_row) begin
      c  = mx(a + 1, mx(t_col + busy_last, t_act + T_RCD));
      tg = (t_col + busy_last > a + 1) ? "R9" : "R3";
    end else begin
      if (m_open) begin
        p = mx(a + 1, mx(t_act + T_RAS, t_col + cp_last));
        if (p == t_act + T_RAS && p > a + 1) tg = "R7";
        else if (p == t_col + cp_last && p > a + 1 && m_last_wr) tg = "R8";
        else tg = "R4";
        push(p, 4'b1000, m_row, '0, 1'b0, 1'b0, tg);
        act = mx(p + 1, p + T_RP);
        push(act, 4'b0001, row, '0, 1'b0, 1'b0, "R6");
        tg = "R4";
      end else begin
        act = mx(a + 1, t_close + T_RP);
        push(act, 4'b0001, row, '0, 1'b0, 1'b0,
             m_first ? "R1" : (m_auto ? "R11" : "R6"));
        tg = "R5";
      end
      t_act = act;
      m_row = row;
      c = mx(act + 1, mx(act + T_RCD, t_col + busy_last));
    end
    push(c, wr ? 4'b0100 : 4'b0010, '0, col, ap, b16, tg);
    t_col     = c;
    busy_last = b16 ? 8 : 4;
    cp_last   = wr ? (T_CL + busy_last + T_WR) : busy_last;
    m_last_wr = wr;
    m_first   = 0;
    if (ap) begin
      m_open  = 0;
      m_auto  = 1;
      t_close = mx(c + 1, mx(t_act + T_RAS, c + cp_last));
    end else begin
      m_open = 1;
    end
    @(negedge clk);
    checks++;
    if (req_ready !== 1'b0) begin
      errors++;
      $display("FAIL R12: req_ready after accept got %b exp 0", req_ready);
    end
  endtask

  // monitor and comparator
  initial begin
    item_t o, e;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_strobe != 4'b0) begin
        o.c = cyc; o.cmd = cmd_strobe; o.row = cmd_row; o.col = cmd_col;
        o.ap = cmd_auto_pre; o.b16 = cmd_burst16; o.tag = "";
        obs_q.push_back(o);
        checks++;
        if ($countones(cmd_strobe) != 1) begin
          errors++;
          $display("FAIL R2: strobe got %b exp one-hot", cmd_strobe);
        end
      end
      while (exp_q.size() > 0 && obs_q.size() > 0) begin
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        checks++;
        if (o.c != e.c || o.cmd !== e.cmd || o.row !== e.row || o.col !== e.col ||
            o.ap !== e.ap || o.b16 !== e.b16) begin
          errors++;
          $display("FAIL %s: got cyc=%0d cmd=%b row=%0d col=%0d ap=%b b16=%b exp cyc=%0d cmd=%b row=%0d col=%0d ap=%b b16=%b",
                   e.tag, o.c, o.cmd, o.row, o.col, o.ap, o.b16,
                   e.c, e.cmd, e.row, e.col, e.ap, e.b16);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_auto_pre = 1'b0;
    req_burst16 = 1'b0; req_row = '0; req_col = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (cmd_strobe !== 4'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1: reset strobe=%b ready=%b exp strobe=0000 ready=1",
               cmd_strobe, req_ready);
    end
    do_req(14'd5, 10'd1, 1'b0, 1'b0, 1'b0);  // R1 first open, R5
    do_req(14'd5, 10'd2, 1'b0, 1'b0, 1'b0);  // R9 back-to-back hit
    repeat (8) @(negedge clk);
    do_req(14'd5, 10'd3, 1'b0, 1'b0, 1'b0);  // R3 free hit
    do_req(14'd5, 10'd4, 1'b1, 1'b0, 1'b1);  // write, long burst
    do_req(14'd9, 10'd5, 1'b0, 1'b0, 1'b0);  // R8 conflict after write
    do_req(14'd2, 10'd6, 1'b0, 1'b0, 1'b0);  // conflict
    do_req(14'd7, 10'd7, 1'b0, 1'b0, 1'b1);  // R7 conflict held by row-open time
    repeat (40) @(negedge clk);              // R10 idle close
    do_req(14'd7, 10'd8, 1'b0, 1'b0, 1'b0);  // reopen after idle close, R6
    do_req(14'd7, 10'd9, 1'b1, 1'b1, 1'b0);  // R11 write with auto close
    do_req(14'd7, 10'd10, 1'b0, 1'b0, 1'b0); // R11 same row must reopen
    do_req(14'd3, 10'd11, 1'b0, 1'b1, 1'b1); // conflict, read auto close
    do_req(14'd3, 10'd12, 1'b1, 1'b0, 1'b0); // R11 reopen
    repeat (60) @(negedge clk);
    note_timeout(cyc);
    repeat (5) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || obs_q.size() != 0) begin
      errors++;
      $display("FAIL R4: leftover commands got obs=%0d exp_left=%0d exp 0 0",
               obs_q.size(), exp_q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule